// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral supervises software through a down-counter on a simple register bus that completes each access in one cycle. Once running, the counter counts down from a programmed load value. The first time it reaches zero it raises an interrupt and starts a second pass from the load value. If software has not cleared that interrupt by the time the second pass ends, and the reset path is enabled, the block raises a reset request. The request stays asserted until the block itself is reset.

Software must keep its writes deliberate. All register writes are refused until a 32-bit unlock key has been written to the lock register. Any other value written there locks the registers again. Writing to the interrupt clear register serves as the keep-alive: it clears the pending interrupt and restarts the count. A full timeout from a fresh reload takes two passes of load+1 cycles each.

Top module: `wdog_dual_stage`

## Requirements
- R1: After reset, lock (0xC00) reads 1, load (0x000) reads 0xFFFFFFFF, count (0x004) reads 0xFFFFFFFF, control (0x008), raw status (0x010) and masked status (0x014) read 0, and both outputs are low.
- R2: Writing 0x1ACCE551 to 0xC00 unlocks the registers, and 0xC00 then reads 0. Writing any other value there locks them, and 0xC00 then reads 1. Writes to 0xC00 are accepted in either state.
- R3: While locked, writes to load, control and interrupt clear are ignored and leave the load value, control bits, count and status unchanged.
- R4: An unlocked write to 0x000 stores the load value and places that value in the count on the same clock edge.
- R5: While control bit 0 is set and the count is not zero, the count falls by one each cycle, so one pass lasts load+1 cycles.
- R6: When a running count reaches zero with no interrupt pending, the pending bit (bit 0 of 0x010) sets and the count reloads from the load value.
- R7: When a running count reaches zero with the interrupt already pending and control bit 1 set, the reset request rises. It stays high until the block reset, whatever is written afterwards. With control bit 1 clear, the count only reloads.
- R8: An unlocked write of any value to 0x00C clears the pending bit and reloads the count from the load value.
- R9: Bit 0 of 0x014 and the output irq_o both equal the pending bit ANDed with control bit 0. Bit 0 of 0x010 shows the pending bit regardless of control.
- R10: With control bit 0 clear, the count holds its value, and no interrupt or reset request is generated.
- R11: If a reloading write (to 0x000 or 0x00C) falls in the cycle in which the count would expire, the write wins and that expiry is discarded: it sets no interrupt and raises no reset request.
- R12: Control reads back as bits [1:0] with zeros above. Status and lock read back in bit 0 only. The clear register and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Masked interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
Two functions can fall in the same cycle: a keep-alive or load write, and the count's expiry at zero. The bench counts cycles in its own model so that it can place an interrupt-clear write exactly on the cycle where the count sits at zero with the interrupt pending and the reset path enabled. It then checks that no reset request appears, that the pending bit is clear and that the count restarts from the load value. Random traffic with small load values makes the same collision, and its load-write form, happen many more times. Every cycle is compared against the bench model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Value that opens the register file for writing
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef enum logic [2:0] {
    SEL_LOAD, SEL_COUNT, SEL_CTRL, SEL_CLEAR,
    SEL_RAW, SEL_MASKED, SEL_LOCK, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic rst_en;  // bit 1: second expiry may request reset
    logic run_en;  // bit 0: counter and interrupt enabled
  } ctrl_t;

  // Next count: writes first, then the running decrement with reload at zero.
  function automatic logic [31:0] next_count(
    input logic [31:0] cur,
    input logic [31:0] load_val,
    input logic [31:0] wdata,
    input logic        run,
    input logic        load_wr,
    input logic        clear_wr
  );
    if (load_wr)        return wdata;
    else if (clear_wr)  return load_val;
    else if (!run)      return cur;
    else if (cur == '0) return load_val;
    else                return cur - 32'd1;
  endfunction

endpackage

// File: rtl/wdog_lock.sv
module wdog_lock #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  import wdog_pkg::*;

  localparam logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n)       locked <= 1'b1;
    else if (lock_wr) locked <= (wdata != KEY);
  end
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_wr,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] load_wdata,
  input  logic [1:0]       ctrl_wdata,
  output logic [CNT_W-1:0] load_q,
  output wdog_pkg::ctrl_t  ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '1;
      ctrl_q <= '0;
    end else begin
      if (load_wr) load_q <= load_wdata;
      if (ctrl_wr) ctrl_q <= wdog_pkg::ctrl_t'(ctrl_wdata);
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_wr,
  input  logic             clear_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_q,
  output logic             pend_q,
  output logic             rst_req_q,
  output logic             expire_ev
);
  import wdog_pkg::*;

  logic             at_zero;
  logic             reload_wr;
  logic [CNT_W-1:0] count_d;

  assign at_zero   = run_en && (count_q == '0);
  assign reload_wr = load_wr || clear_wr;
  // An expiry coinciding with a reloading write is dropped (write wins)
  assign expire_ev = at_zero && !reload_wr;

  assign count_d = CNT_W'(next_count(32'(count_q), 32'(load_val), 32'(wdata),
                                     run_en, load_wr, clear_wr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '1;
      pend_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      count_q <= count_d;
      if (clear_wr)       pend_q <= 1'b0;
      else if (expire_ev) pend_q <= 1'b1;
      if (expire_ev && pend_q && rst_en) rst_req_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_dual_stage.sv
module wdog_dual_stage #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  import wdog_pkg::*;

  localparam logic [ADDR_W-1:0] OFS_LOAD   = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_COUNT  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFS_RAW    = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFS_MASKED = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] OFS_LOCK   = ADDR_W'(12'hC00);

  reg_sel_e         sel;
  logic             locked;
  logic             wr_ok;
  logic             ld_wr, ctl_wr, clr_wr, lk_wr;
  logic [CNT_W-1:0] load_val;
  ctrl_t            ctrl_q;
  logic             run_en, rst_en;
  logic [CNT_W-1:0] cnt_val;
  logic             pend;
  logic             exp_ev;

  always_comb begin
    case (bus_addr)
      OFS_LOAD:   sel = SEL_LOAD;
      OFS_COUNT:  sel = SEL_COUNT;
      OFS_CTRL:   sel = SEL_CTRL;
      OFS_CLEAR:  sel = SEL_CLEAR;
      OFS_RAW:    sel = SEL_RAW;
      OFS_MASKED: sel = SEL_MASKED;
      OFS_LOCK:   sel = SEL_LOCK;
      default:    sel = SEL_NONE;
    endcase
  end

  assign wr_ok  = bus_we && !locked;
  assign lk_wr  = bus_we && (sel == SEL_LOCK);
  assign ld_wr  = wr_ok && (sel == SEL_LOAD);
  assign ctl_wr = wr_ok && (sel == SEL_CTRL);
  assign clr_wr = wr_ok && (sel == SEL_CLEAR);

  wdog_lock #(.DATA_W(CNT_W)) lock_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_wr (lk_wr),
    .wdata   (bus_wdata),
    .locked  (locked)
  );

  wdog_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_wr    (ld_wr),
    .ctrl_wr    (ctl_wr),
    .load_wdata (bus_wdata),
    .ctrl_wdata (bus_wdata[1:0]),
    .load_q     (load_val),
    .ctrl_q     (ctrl_q)
  );

  assign run_en = ctrl_q.run_en;
  assign rst_en = ctrl_q.rst_en;

  wdog_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .rst_en    (rst_en),
    .load_val  (load_val),
    .load_wr   (ld_wr),
    .clear_wr  (clr_wr),
    .wdata     (bus_wdata),
    .count_q   (cnt_val),
    .pend_q    (pend),
    .rst_req_q (rst_req_o),
    .expire_ev (exp_ev)
  );

  assign irq_o = pend && run_en;

  always_comb begin
    case (sel)
      SEL_LOAD:   bus_rdata = load_val;
      SEL_COUNT:  bus_rdata = cnt_val;
      SEL_CTRL:   bus_rdata = CNT_W'(ctrl_q);
      SEL_RAW:    bus_rdata = CNT_W'(pend);
      SEL_MASKED: bus_rdata = CNT_W'(irq_o);
      SEL_LOCK:   bus_rdata = CNT_W'(locked);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_dual_stage_chk.sv
module wdog_dual_stage_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              locked,
  input logic [CNT_W-1:0]  load_val,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              pend,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic              exp_ev,
  input logic              ld_wr,
  input logic              clr_wr,
  input logic              run_en,
  input logic              rst_en
);
  AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_we && bus_addr == '0) |=> $stable(load_val)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cnt_val != '0 && !ld_wr && !clr_wr) |=> (cnt_val == $past(cnt_val) - CNT_W'(1))); // R5
  AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_ev && !pend) |=> pend); // R6
  AST_SECOND_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_ev && pend && rst_en) |=> rst_req_o); // R7
  AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> rst_req_o); // R7
  AST_CLEAR_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !pend); // R8
  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !irq_o); // R9
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !ld_wr && !clr_wr) |=> $stable(cnt_val)); // R10
  AST_WRITE_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && run_en && cnt_val == '0 && pend && !rst_req_o) |=> !rst_req_o); // R11
endmodule

bind wdog_dual_stage wdog_dual_stage_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .locked    (locked),
  .load_val  (load_val),
  .cnt_val   (cnt_val),
  .pend      (pend),
  .rst_req_o (rst_req_o),
  .irq_o     (irq_o),
  .exp_ev    (exp_ev),
  .ld_wr     (ld_wr),
  .clr_wr    (clr_wr),
  .run_en    (run_en),
  .rst_en    (rst_en)
);

// File: tb/wdog_dual_stage_tb.sv
`timescale 1ns/1ps
module wdog_dual_stage_tb_top;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int n_checks = 0;
  int n_errors = 0;

  // Bench model of the register state
  logic        m_lock;
  logic [31:0] m_load, m_cnt;
  logic [1:0]  m_ctrl;
  logic        m_pend, m_rst;

  always #5 clk = ~clk;

  wdog_dual_stage dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    m_lock = 1'b1; m_load = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF;
    m_ctrl = 2'b00; m_pend = 1'b0; m_rst = 1'b0;
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h000: return m_load;
      12'h004: return m_cnt;
      12'h008: return {30'b0, m_ctrl};
      12'h010: return {31'b0, m_pend};
      12'h014: return {31'b0, m_pend & m_ctrl[0]};
      12'hC00: return {31'b0, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h000: return "R4";
      12'h004: return "R5";
      12'h008: return "R3";
      12'h010, 12'h014: return "R9";
      12'hC00: return "R2";
      default: return "R12";
    endcase
  endfunction

  // One clock cycle of the model, written from the requirements
  task automatic model_step(input logic we, input logic [11:0] a, input logic [31:0] d);
    logic ok, ldw, clw, expire;
    ok  = we && !m_lock && (a != 12'hC00);
    ldw = ok && (a == 12'h000);
    clw = ok && (a == 12'h00C);
    expire = m_ctrl[0] && (m_cnt == 0) && !ldw && !clw;
    if (expire && m_pend && m_ctrl[1]) m_rst = 1'b1;
    if (clw) m_pend = 1'b0;
    else if (expire) m_pend = 1'b1;
    if (ldw) m_cnt = d;
    else if (clw) m_cnt = m_load;
    else if (m_ctrl[0]) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
    if (ldw) m_load = d;
    if (ok && a == 12'h008) m_ctrl = d[1:0];
    if (we && a == 12'hC00) m_lock = (d != KEY);
  endtask

  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(we, a, d);
    #2;
    chk(tag_of(a), bus_rdata, exp_read(a));
    chk("R9", {31'b0, irq_o}, {31'b0, m_pend & m_ctrl[0]});
    chk("R7", {31'b0, rst_req_o}, {31'b0, m_rst});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_init();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    step(0, 12'hC00, 0); chk("R1", bus_rdata, 32'h1);
    step(0, 12'h000, 0); chk("R1", bus_rdata, 32'hFFFF_FFFF);
    step(0, 12'h004, 0); chk("R1", bus_rdata, 32'hFFFF_FFFF);
    step(0, 12'h008, 0); chk("R1", bus_rdata, 32'h0);
    chk("R1", {30'b0, irq_o, rst_req_o}, 32'h0);

    // R3 locked writes ignored
    step(1, 12'h000, 32'd9);  step(0, 12'h000, 0); chk("R3", bus_rdata, 32'hFFFF_FFFF);
    step(1, 12'h008, 32'd3);  step(0, 12'h008, 0); chk("R3", bus_rdata, 32'h0);

    // R2 unlock, relock, unlock
    step(1, 12'hC00, KEY);         chk("R2", bus_rdata, 32'h0);
    step(1, 12'hC00, 32'h1234);    chk("R2", bus_rdata, 32'h1);
    step(1, 12'hC00, KEY);

    // R4 load write reloads the count
    step(1, 12'h000, 32'd5);  chk("R4", bus_rdata, 32'd5);
    step(0, 12'h004, 0);      chk("R4", bus_rdata, 32'd5);

    // R5/R6 enable, count 5..0, expiry on the sixth cycle
    step(1, 12'h008, 32'd1);
    for (int i = 4; i >= 0; i--) begin
      step(0, 12'h004, 0); chk("R5", bus_rdata, 32'(i));
    end
    step(0, 12'h010, 0); chk("R6", bus_rdata, 32'h1); chk("R9", {31'b0, irq_o}, 32'h1);
    step(0, 12'h004, 0); chk("R6", bus_rdata, 32'd4);

    // R11 clear lands on the expiry cycle while pending with reset enabled
    step(1, 12'h008, 32'd3);
    repeat (3) step(0, 12'h004, 0);
    chk("R11", bus_rdata, 32'd0);
    step(1, 12'h00C, 32'hDEAD);
    chk("R11", {31'b0, rst_req_o}, 32'h0);
    step(0, 12'h010, 0); chk("R11", bus_rdata, 32'h0);

    // R7 two passes end in reset, which then sticks
    repeat (12) step(0, 12'h010, 0);
    chk("R7", {31'b0, rst_req_o}, 32'h1);
    step(1, 12'h00C, 0); step(1, 12'h008, 32'd0);
    repeat (3) step(0, 12'h004, 0);
    chk("R7", {31'b0, rst_req_o}, 32'h1);

    // R10 halted count holds
    held = bus_rdata;
    repeat (4) step(0, 12'h004, 0);
    chk("R10", bus_rdata, held);

    // R8 clear reloads from load
    step(1, 12'h00C, 0); chk("R8", bus_rdata, 32'h0);
    step(0, 12'h004, 0); chk("R8", bus_rdata, 32'd5);

    // R3/R12 relock then attempt writes
    step(1, 12'hC00, 32'h0);
    step(1, 12'h000, 32'd7); step(0, 12'h000, 0); chk("R3", bus_rdata, 32'd5);
    step(1, 12'h008, 32'd1); step(0, 12'h008, 0); chk("R3", bus_rdata, 32'd0);
    step(0, 12'h00C, 0); chk("R12", bus_rdata, 32'h0);
    step(0, 12'h040, 0); chk("R12", bus_rdata, 32'h0);

    // Random traffic with small loads so expiry and writes collide
    for (int blk = 0; blk < 8; blk++) begin
      do_reset();
      for (int n = 0; n < 500; n++) begin
        logic [11:0] a;
        logic [31:0] d;
        logic        we;
        case ($urandom_range(0, 8))
          0, 1: a = 12'h000;
          2: a = 12'h004;
          3: a = 12'h008;
          4: a = 12'h00C;
          5: a = 12'h010;
          6: a = 12'h014;
          7: a = 12'hC00;
          default: a = 12'h020;
        endcase
        we = ($urandom_range(0, 3) == 0);
        if (a == 12'h000) d = $urandom_range(0, 12);
        else if (a == 12'hC00) d = ($urandom_range(0, 3) != 0) ? KEY : $urandom;
        else d = $urandom;
        step(we, a, d);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule